// File: doc/BRIEF.md
# Gate Interval Command Encoder

This block turns a list of time-gate schedule entries into command words for a gate command memory. Each entry carries an interval in nanoseconds and an 8-bit gate mask. The interval is converted into a count of byte times at the current link speed. A count too large for one command is split across several commands. A small nonzero count is raised to a floor value. After the list, one closing command is added that closes every gate the list ever opened.

Entries arrive on a valid/ready stream and are held in a small buffer until the entry marked last arrives, or until the buffer fills. A first pass works out how many commands the list needs. If the list does not fit in one bank of 64 commands, the encoder raises an overflow flag and writes nothing. Otherwise a second pass writes the commands into the bank chosen by the bank select input, one word per write strobe. One shared sequential divider does all the divisions.

Top module: `gateCmdEncoder`

## Requirements
- R1: At link speeds of 1000 Mb/s or more, an entry's count is ceil(intervalNs * linkSpeed / 8000).
- R2: At link speeds below 1000 Mb/s, the product intervalNs * linkSpeed is doubled before the rounded-up division by 8000.
- R3: Each command word is {count in bits 21:8, mask in bits 7:0}. A count above 16383 is written as repeated commands of 16383 that share the entry's mask, followed by one command that carries the remainder.
- R4: A nonzero final count below 16 is written as 16. No written command has a count between 1 and 15.
- R5: An entry whose count is zero is written as one command with count 0. Every entry after it in the same list produces no command.
- R6: After the list's commands, if fewer than 64 commands were written, one closing command is written with count 0 and a mask equal to the bitwise inverse of the OR of the masks of all nonzero-count entries. A list that fills the bank exactly gets no closing command.
- R7: A list that needs more than 64 commands (closing command not counted) sets overflow together with done, and no command is written.
- R8: Bank 0 uses word addresses 0 to 63 and bank 1 uses 64 to 127. Successive commands of one list go to consecutive addresses starting at the bank base.
- R9: After reset, entryReady is 1 and done, overflow and memWe are 0. Entries are accepted only while entryReady is 1. A list ends at the entry with entryLast set or at the 8th entry. done stays 1 once the list is processed and clears when the next entry is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| entryValid | input | 1 | Entry stream valid |
| entryReady | output | 1 | Entry stream ready |
| entryNs | input | 32 | Entry interval in nanoseconds |
| entryMask | input | 8 | Entry gate mask |
| entryLast | input | 1 | Marks the final entry of a list |
| linkSpeed | input | 16 | Link speed in Mb/s; hold stable while a list is processed |
| bankSel | input | 1 | Target bank; sampled when the list closes |
| memWe | output | 1 | Command memory write strobe |
| memAddr | output | 7 | Command memory word address |
| memData | output | 22 | Command word {count, mask} |
| done | output | 1 | List processed |
| overflow | output | 1 | Last list rejected for lack of space |

## Verification
On every cycle, the assertions check that each write lands inside the selected bank and follows the previous write of the same list at the next address. They also check that no written count falls between 1 and 15, that overflow is never reported without done, and that a rejected list leaves no write behind. Only the bench scenarios can show the arithmetic itself. That covers the rounding of the count at both speed ranges, where a long interval splits, the cut-off after a zero-count entry, the value of the closing mask, and the exact-fill case in which the closing command is left out.

// File: rtl/gce_pkg.sv
package gce_pkg;
  // Strobes issued by the controller to the datapath each cycle
  typedef struct packed {
    logic clrList;
    logic pushEntry;
    logic startPass;
    logic divStart;
    logic divSelCmd;
    logic loadCnt;
    logic accCmds;
    logic emitCmd;
    logic emitClose;
    logic nextIdx;
  } gceStrobes_t;

  // Conditions reported by the datapath to the controller
  typedef struct packed {
    logic bufFull;
    logic lastSlot;
    logic divDone;
    logic cntZero;
    logic lastIdx;
    logic remBig;
    logic overflowDet;
  } gceStatus_t;
endpackage

// File: rtl/gceDivider.sv
module gceDivider #(
  parameter int W = 49
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         doneP
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0] divQ, divR, divDen;
  logic [CW-1:0] divCnt;
  logic divBusy;
  logic [W:0] trial;
  logic ge;

  assign trial = {divR, divQ[W-1]};
  assign ge    = trial >= {1'b0, divDen};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divQ <= '0; divR <= '0; divDen <= '0;
      divCnt <= '0; divBusy <= 1'b0; doneP <= 1'b0;
    end else if (start) begin
      divQ <= num; divR <= '0; divDen <= den;
      divCnt <= CW'(W); divBusy <= 1'b1; doneP <= 1'b0;
    end else if (divBusy) begin
      divR   <= ge ? W'(trial - {1'b0, divDen}) : trial[W-1:0];
      divQ   <= {divQ[W-2:0], ge};
      divCnt <= divCnt - 1'b1;
      if (divCnt == CW'(1)) begin
        divBusy <= 1'b0;
        doneP   <= 1'b1;
      end
    end else begin
      doneP <= 1'b0;
    end
  end

  assign quot = divQ;
  assign rem  = divR;
endmodule

// File: rtl/gceDatapath.sv
module gceDatapath
  import gce_pkg::*;
#(
  parameter int NS_W      = 32,
  parameter int SPD_W     = 16,
  parameter int MASK_W    = 8,
  parameter int CNT_W     = 14,
  parameter int DEPTH     = 8,
  parameter int BANK_CMDS = 64,
  parameter int MIN_CNT   = 16,
  parameter int BYTE_DIV  = 8000,
  parameter int GIG_SPD   = 1000,
  localparam int PROD_W   = NS_W + SPD_W + 1,
  localparam int IDX_W    = $clog2(DEPTH),
  localparam int OFF_W    = $clog2(BANK_CMDS + 1),
  localparam int ADDR_W   = $clog2(BANK_CMDS) + 1,
  localparam int DATA_W   = CNT_W + MASK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  gceStrobes_t       st,
  output gceStatus_t        sts,
  input  logic [NS_W-1:0]   inNs,
  input  logic [MASK_W-1:0] inMask,
  input  logic [SPD_W-1:0]  linkSpeed,
  input  logic              bankSel,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  localparam int MAX_CNT = (1 << CNT_W) - 1;
  localparam int TOT_W   = OFF_W + 1;
  localparam int TOT_LIM = BANK_CMDS + 1;

  logic [NS_W-1:0]   entNs   [DEPTH];
  logic [MASK_W-1:0] entMask [DEPTH];
  logic [IDX_W:0]    numStored;
  logic [IDX_W-1:0]  idx;
  logic [PROD_W-1:0] prod, divNum, divDen, quot, rem, ceilQ, cntReg, remCnt;
  logic [TOT_W-1:0]  total;
  logic [PROD_W:0]   sum;
  logic [OFF_W-1:0]  off;
  logic [MASK_W-1:0] maskOr, curMask;
  logic              bankR, divDone;
  logic [CNT_W-1:0]  lastCnt;

  always_comb begin
    prod = PROD_W'(entNs[idx]) * PROD_W'(linkSpeed);
    if (linkSpeed < SPD_W'(GIG_SPD)) prod = prod << 1;
  end

  assign divNum  = st.divSelCmd ? cntReg + PROD_W'(MAX_CNT - 1) : prod;
  assign divDen  = st.divSelCmd ? PROD_W'(MAX_CNT) : PROD_W'(BYTE_DIV);
  assign ceilQ   = quot + PROD_W'(rem != '0);
  assign curMask = entMask[idx];
  assign sum     = (PROD_W + 1)'(total) + ((cntReg == '0) ? (PROD_W + 1)'(1) : {1'b0, quot});
  assign lastCnt = (remCnt != '0 && remCnt < PROD_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : remCnt[CNT_W-1:0];

  gceDivider #(.W(PROD_W)) u_div (
    .clk(clk), .rstN(rstN), .start(st.divStart), .num(divNum), .den(divDen),
    .quot(quot), .rem(rem), .doneP(divDone)
  );

  always_ff @(posedge clk) begin
    if (st.pushEntry) begin
      entNs[numStored[IDX_W-1:0]]   <= inNs;
      entMask[numStored[IDX_W-1:0]] <= inMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      numStored <= '0; idx <= '0; cntReg <= '0; remCnt <= '0; total <= '0;
      off <= '0; maskOr <= '0; bankR <= 1'b0;
      memWe <= 1'b0; memAddr <= '0; memData <= '0;
    end else begin
      memWe <= 1'b0;
      if (st.clrList) numStored <= '0;
      else if (st.pushEntry) numStored <= numStored + 1'b1;
      if (st.startPass) begin
        idx <= '0; total <= '0; off <= '0; maskOr <= '0; bankR <= bankSel;
      end
      if (st.nextIdx) idx <= idx + 1'b1;
      if (st.loadCnt) begin
        cntReg <= ceilQ;
        remCnt <= ceilQ;
      end
      if (st.accCmds) total <= (sum > (PROD_W + 1)'(TOT_LIM)) ? TOT_W'(TOT_LIM) : sum[TOT_W-1:0];
      if (st.emitCmd) begin
        memWe   <= 1'b1;
        memAddr <= {bankR, off[ADDR_W-2:0]};
        off     <= off + 1'b1;
        if (remCnt > PROD_W'(MAX_CNT)) begin
          memData <= {CNT_W'(MAX_CNT), curMask};
          remCnt  <= remCnt - PROD_W'(MAX_CNT);
        end else begin
          memData <= {lastCnt, curMask};
          remCnt  <= '0;
        end
        if (cntReg != '0) maskOr <= maskOr | curMask;
      end
      if (st.emitClose && off < OFF_W'(BANK_CMDS)) begin
        memWe   <= 1'b1;
        memAddr <= {bankR, off[ADDR_W-2:0]};
        memData <= {CNT_W'(0), ~maskOr};
        off     <= off + 1'b1;
      end
    end
  end

  assign sts.bufFull     = numStored == (IDX_W + 1)'(DEPTH);
  assign sts.lastSlot    = numStored == (IDX_W + 1)'(DEPTH - 1);
  assign sts.divDone     = divDone;
  assign sts.cntZero     = cntReg == '0;
  assign sts.lastIdx     = {1'b0, idx} == numStored - 1'b1;
  assign sts.remBig      = remCnt > PROD_W'(MAX_CNT);
  assign sts.overflowDet = total > TOT_W'(BANK_CMDS);
endmodule

// File: rtl/gceCtrl.sv
module gceCtrl
  import gce_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        entryValid,
  input  logic        entryLast,
  output logic        entryReady,
  input  gceStatus_t  sts,
  output gceStrobes_t st,
  output logic        done,
  output logic        overflow
);
  typedef enum logic [2:0] {
    S_IDLE, S_DIV1, S_WAIT1, S_DIV2, S_WAIT2, S_CHECK, S_EMIT, S_CLOSE
  } state_t;

  state_t state, nxt;
  logic pass2, accept;

  assign entryReady = (state == S_IDLE) && !sts.bufFull;
  assign accept     = entryValid && entryReady;

  always_comb begin
    st  = '0;
    nxt = state;
    case (state)
      S_IDLE: if (accept) begin
        st.pushEntry = 1'b1;
        if (entryLast || sts.lastSlot) begin
          st.startPass = 1'b1;
          nxt = S_DIV1;
        end
      end
      S_DIV1: begin
        st.divStart = 1'b1;
        nxt = S_WAIT1;
      end
      S_WAIT1: if (sts.divDone) begin
        st.loadCnt = 1'b1;
        nxt = pass2 ? S_EMIT : S_DIV2;
      end
      S_DIV2: begin
        st.divStart  = 1'b1;
        st.divSelCmd = 1'b1;
        nxt = S_WAIT2;
      end
      S_WAIT2: if (sts.divDone) begin
        st.accCmds = 1'b1;
        if (sts.cntZero || sts.lastIdx) nxt = S_CHECK;
        else begin
          st.nextIdx = 1'b1;
          nxt = S_DIV1;
        end
      end
      S_CHECK: begin
        if (sts.overflowDet) begin
          st.clrList = 1'b1;
          nxt = S_IDLE;
        end else begin
          st.startPass = 1'b1;
          nxt = S_DIV1;
        end
      end
      S_EMIT: begin
        st.emitCmd = 1'b1;
        if (!sts.remBig) begin
          if (sts.cntZero || sts.lastIdx) nxt = S_CLOSE;
          else begin
            st.nextIdx = 1'b1;
            nxt = S_DIV1;
          end
        end
      end
      S_CLOSE: begin
        st.emitClose = 1'b1;
        st.clrList   = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE; pass2 <= 1'b0; done <= 1'b0; overflow <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        done <= 1'b0;
        overflow <= 1'b0;
      end
      if (state == S_CHECK) begin
        if (sts.overflowDet) begin
          done <= 1'b1;
          overflow <= 1'b1;
        end else pass2 <= 1'b1;
      end
      if (state == S_CLOSE) begin
        done  <= 1'b1;
        pass2 <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/gateCmdEncoder.sv
module gateCmdEncoder
  import gce_pkg::*;
#(
  parameter int NS_W      = 32,
  parameter int SPD_W     = 16,
  parameter int MASK_W    = 8,
  parameter int CNT_W     = 14,
  parameter int DEPTH     = 8,
  parameter int BANK_CMDS = 64,
  localparam int ADDR_W   = $clog2(BANK_CMDS) + 1,
  localparam int DATA_W   = CNT_W + MASK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              entryValid,
  output logic              entryReady,
  input  logic [NS_W-1:0]   entryNs,
  input  logic [MASK_W-1:0] entryMask,
  input  logic              entryLast,
  input  logic [SPD_W-1:0]  linkSpeed,
  input  logic              bankSel,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              done,
  output logic              overflow
);
  gceStrobes_t st;
  gceStatus_t  sts;

  gceCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .entryValid(entryValid), .entryLast(entryLast),
    .entryReady(entryReady), .sts(sts), .st(st), .done(done), .overflow(overflow)
  );

  gceDatapath #(
    .NS_W(NS_W), .SPD_W(SPD_W), .MASK_W(MASK_W), .CNT_W(CNT_W),
    .DEPTH(DEPTH), .BANK_CMDS(BANK_CMDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .sts(sts), .inNs(entryNs), .inMask(entryMask),
    .linkSpeed(linkSpeed), .bankSel(bankSel),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/gceChecker.sv
module gceChecker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 22,
  parameter int MASK_W = 8,
  parameter int MIN_CNT = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              entryValid,
  input logic              entryReady,
  input logic              bankSel,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memData,
  input logic              done,
  input logic              overflow
);
  logic              seenWrite;
  logic [ADDR_W-1:0] lastAddr;
  logic [DATA_W-MASK_W-1:0] wCnt;

  assign wCnt = memData[DATA_W-1:MASK_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenWrite <= 1'b0;
      lastAddr  <= '0;
    end else if (entryValid && entryReady) begin
      seenWrite <= 1'b0;
    end else if (memWe) begin
      seenWrite <= 1'b1;
      lastAddr  <= memAddr;
    end
  end

  // R8: every write stays in the selected bank
  a_r8_addr_in_bank: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr[ADDR_W-1] == bankSel);

  // R8: consecutive writes of one list step by one word
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && seenWrite) |-> memAddr == lastAddr + 1'b1);

  // R4: no written count between 1 and MIN_CNT-1
  a_r4_min_count: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (wCnt == '0 || wCnt >= (DATA_W-MASK_W)'(MIN_CNT)));

  // R7: overflow is only reported alongside done
  a_r7_overflow_done: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> done);

  // R7: a rejected list has written nothing
  a_r7_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (done && overflow) |-> !seenWrite);
endmodule

bind gateCmdEncoder gceChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_W(MASK_W)
) u_chk (
  .clk(clk), .rstN(rstN), .entryValid(entryValid), .entryReady(entryReady),
  .bankSel(bankSel), .memWe(memWe), .memAddr(memAddr), .memData(memData),
  .done(done), .overflow(overflow)
);

// File: tb/tb_gateCmdEncoder.sv
module tb_gateCmdEncoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic entryValid = 1'b0, entryLast = 1'b0, bankSel = 1'b0;
  logic [31:0] entryNs = '0;
  logic [7:0]  entryMask = '0;
  logic [15:0] linkSpeed = 16'd1000;
  logic entryReady, memWe, done, overflow;
  logic [6:0]  memAddr;
  logic [21:0] memData;

  always #2 clk = ~clk;

  gateCmdEncoder dut (
    .clk(clk), .rstN(rstN), .entryValid(entryValid), .entryReady(entryReady),
    .entryNs(entryNs), .entryMask(entryMask), .entryLast(entryLast),
    .linkSpeed(linkSpeed), .bankSel(bankSel), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .done(done), .overflow(overflow)
  );

  int tests = 0, fails = 0;
  int wrCount = 0;
  logic [6:0]  capAddr [0:1023];
  logic [21:0] capData [0:1023];

  always @(negedge clk) if (rstN && memWe) begin
    capAddr[wrCount] = memAddr;
    capData[wrCount] = memData;
    wrCount = wrCount + 1;
  end

  logic [31:0] tNs [0:7];
  logic [7:0]  tMask [0:7];
  logic [21:0] expD [0:255];
  int expN;
  bit expOv;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic buildExp(input int n, input int spd);
    longint prod, cnt, r, w;
    int cmds;
    logic [7:0] orm;
    cmds = 0; orm = '0; expN = 0;
    for (int i = 0; i < n; i++) begin
      prod = longint'(tNs[i]) * spd;
      if (spd < 1000) prod = prod * 2;
      cnt = (prod + 7999) / 8000;
      cmds += (cnt == 0) ? 1 : int'((cnt + 16382) / 16383);
      if (cnt == 0) break;
    end
    expOv = cmds > 64;
    if (expOv) return;
    for (int i = 0; i < n; i++) begin
      prod = longint'(tNs[i]) * spd;
      if (spd < 1000) prod = prod * 2;
      cnt = (prod + 7999) / 8000;
      r = cnt;
      do begin
        if (r > 16383) begin w = 16383; r -= 16383; end
        else begin w = (r != 0 && r < 16) ? 16 : r; r = 0; end
        expD[expN] = {w[13:0], tMask[i]};
        expN++;
      end while (r != 0);
      if (cnt == 0) break;
      orm |= tMask[i];
    end
    if (expN < 64) begin
      expD[expN] = {14'd0, ~orm};
      expN++;
    end
  endtask

  task automatic runList(input string tag, input int n, input int spd, input bit bank);
    int start, got, lim;
    linkSpeed = 16'(spd);
    bankSel = bank;
    start = wrCount;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      entryValid = 1'b1; entryNs = tNs[i]; entryMask = tMask[i];
      entryLast = (i == n - 1);
      while (!entryReady) @(negedge clk);
      @(negedge clk);
      entryValid = 1'b0; entryLast = 1'b0;
    end
    lim = 0;
    while (!done && lim < 50000) begin @(negedge clk); lim++; end
    @(negedge clk);
    buildExp(n, spd);
    chk(done == 1'b1, tag, "done", done, 1);
    chk(overflow == expOv, tag, "overflow", overflow, expOv);
    got = wrCount - start;
    chk(got == expN, tag, "write count", got, expN);
    for (int k = 0; k < expN && k < got; k++) begin
      chk(capAddr[start+k] == 7'(bank * 64 + k), tag, "address", capAddr[start+k], bank * 64 + k);
      chk(capData[start+k] == expD[k], tag, "command word", capData[start+k], expD[k]);
    end
  endtask

  task automatic testReset();
    chk(entryReady == 1'b1, "R9", "reset ready", entryReady, 1);
    chk(done == 1'b0, "R9", "reset done", done, 0);
    chk(overflow == 1'b0, "R9", "reset overflow", overflow, 0);
    chk(memWe == 1'b0, "R9", "reset write", memWe, 0);
  endtask

  task automatic testGigabit(); // R1 R6 R8 bank 0, with rounding up
    tNs[0] = 1000; tMask[0] = 8'h01;
    tNs[1] = 2003; tMask[1] = 8'h06;
    tNs[2] = 4000; tMask[2] = 8'h10;
    runList("R1", 3, 1000, 1'b0);
  endtask

  task automatic testSlowLink(); // R2 R8 bank 1
    tNs[0] = 10000; tMask[0] = 8'h80;
    tNs[1] = 3333;  tMask[1] = 8'h03;
    runList("R2", 2, 100, 1'b1);
  endtask

  task automatic testSplit(); // R3 R4: 40000 splits, 16388 leaves 5 -> 16, tiny -> 16
    tNs[0] = 320000; tMask[0] = 8'h21;
    tNs[1] = 131104; tMask[1] = 8'h42;
    tNs[2] = 24;     tMask[2] = 8'h84;
    runList("R3", 3, 1000, 1'b0);
  endtask

  task automatic testZeroEntry(); // R5: later entry ignored
    tNs[0] = 800; tMask[0] = 8'h01;
    tNs[1] = 0;   tMask[1] = 8'h02;
    tNs[2] = 800; tMask[2] = 8'h04;
    runList("R5", 3, 1000, 1'b1);
  endtask

  task automatic testOverflow(); // R7: 65 commands needed
    tNs[0] = 32'd8519160; tMask[0] = 8'hFF;
    runList("R7", 1, 1000, 1'b0);
  endtask

  task automatic testExactFill(); // R6: 64 commands, no closing word
    tNs[0] = 32'd8387584; tMask[0] = 8'h5A;
    runList("R6", 1, 1000, 1'b1);
  endtask

  task automatic testFullBuffer(); // R9: list closes at 8th entry
    for (int i = 0; i < 8; i++) begin
      tNs[i] = 32'(200 * (i + 1));
      tMask[i] = 8'(1 << i);
    end
    runList("R9", 8, 1000, 1'b0);
    chk(entryReady == 1'b1, "R9", "ready after list", entryReady, 1);
  endtask

  bit finished = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testGigabit();
    testSlowLink();
    testSplit();
    testZeroEntry();
    testOverflow();
    testExactFill();
    testFullBuffer();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule